// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Tracker

This block sits on the peripheral side of an IEEE 1284 parallel port and tracks which transfer mode the link is in. It watches the host's select, autofeed, strobe and init lines and the eight data lines. From these it works out whether the port is in compatibility, nibble, byte or ECP mode. The block is always the peripheral and never drives the link. The handshakes that move data inside each mode are handled elsewhere.

A negotiation starts when the host raises its select line while holding autofeed low. This is accepted only while the port sits in compatibility mode. The host then drops strobe, and the extensibility byte on the data lines is captured and decoded into the new mode. A byte that matches no supported mode leaves the port in compatibility mode. When the host drops select again, the port returns to compatibility mode. In ECP mode each edge on the init line reverses the reported data direction.

Software reads the current mode, the captured byte, the direction and two sticky event flags. It clears the flags with write-one-to-clear strobes. All host lines pass through a two-stage synchroniser before any edge is detected.

Top module: `pp_mode_tracker`

## Requirements
- R1: While reset is held and right after it: `mode_o` is 0 (compatibility), and `negotiating_o`, `ext_byte_o`, `rev_dir_o` and both event flags are zero.
- R2: A rising edge on `host_sel_n` while `host_feed_n` is low, in compatibility mode, starts a negotiation. `negotiating_o` goes to 1 and the negotiation flag `neg_evt_flag_o` sets. A select rise while `host_feed_n` is high does nothing.
- R3: During a negotiation, the falling edge of `host_stb_n` captures `host_data` into `ext_byte_o`. Data changes without that edge are not captured.
- R4: The captured byte selects the mode, with `mode_o` encoded as 0 compatibility, 1 nibble, 2 byte, 3 ECP. 0x00 gives nibble, 0x01 gives byte and 0x10 gives ECP; any other value gives compatibility. `negotiating_o` drops in every case.
- R5: `host_sel_n` low, during a negotiation or in any negotiated mode, returns the port to compatibility mode, with `negotiating_o` = 0 and `rev_dir_o` = 0.
- R6: In nibble, byte or ECP mode, strobe falls and data changes leave `ext_byte_o` and `mode_o` unchanged, so no new negotiation takes place.
- R7: The event flags are sticky. Writing `clr_we` = 1 with `clr_mask` bit 0 clears the negotiation flag, and with bit 1 clears the direction flag. A set arriving in the same cycle as a clear wins.
- R8: In ECP mode, every rising or falling edge of `host_init_n` toggles `rev_dir_o` and sets `dir_evt_flag_o`.
- R9: Outside ECP mode, edges on `host_init_n` change neither `rev_dir_o` nor `dir_evt_flag_o`.
- R10: Host inputs are synchronised. An output responds on the third rising clock edge after an input changes, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_sel_n | input | 1 | Host select line (high = negotiate/active mode, low = terminate) |
| host_feed_n | input | 1 | Host autofeed line, low qualifies a negotiation request |
| host_stb_n | input | 1 | Host strobe, falling edge captures the extensibility byte |
| host_init_n | input | 1 | Host init line, edges reverse direction in ECP mode |
| host_data | input | DATA_W | Parallel data lines |
| clr_we | input | 1 | Flag clear write strobe |
| clr_mask | input | 2 | Write-one-to-clear mask: bit 0 negotiation flag, bit 1 direction flag |
| mode_o | output | 2 | Active mode: 0 compat, 1 nibble, 2 byte, 3 ECP |
| ext_byte_o | output | DATA_W | Last captured extensibility byte |
| negotiating_o | output | 1 | Negotiation in progress |
| rev_dir_o | output | 1 | ECP direction, 1 = reversed (peripheral to host) |
| neg_evt_flag_o | output | 1 | Sticky negotiation-start flag |
| dir_evt_flag_o | output | 1 | Sticky direction-change flag |

## Verification
The hardest case to reach from the ports is a new flag set that coincides with a software clear of the same flag. The synchroniser delay makes that edge land three clocks after the host line moves. The bench holds the clear strobe active throughout and raises select. It then samples on the exact cycle the negotiation is recognised and again one cycle later. The same directed run also checks the synchroniser latency. The bench also reaches an ignored negotiation attempt by dropping strobe with a valid mode byte while a mode is already active.

// File: rtl/pp_neg_pkg.sv
// Package: shared types for the parallel port mode tracker.
// Assumes: two-bit mode encoding is visible to software and must not change.
package pp_neg_pkg;

    typedef enum logic [1:0] {
        MODE_COMPAT = 2'd0,
        MODE_NIBBLE = 2'd1,
        MODE_BYTE   = 2'd2,
        MODE_ECP    = 2'd3
    } pp_mode_e;

    typedef enum logic [2:0] {
        ST_COMPAT,
        ST_NEGO,
        ST_NIBBLE,
        ST_BYTE,
        ST_ECP
    } pp_state_e;

    // Bit positions inside the synchronised control vector
    localparam int CTL_SEL  = 0;
    localparam int CTL_FEED = 1;
    localparam int CTL_STB  = 2;
    localparam int CTL_INIT = 3;
    localparam int CTL_W    = 4;

    // Bit positions inside the edge-watched vector
    localparam int EDG_SEL  = 0;
    localparam int EDG_STB  = 1;
    localparam int EDG_INIT = 2;
    localparam int EDG_W    = 3;

    // Event flag indices
    localparam int FLG_NEG = 0;
    localparam int FLG_DIR = 1;
    localparam int FLG_W   = 2;

endpackage

// File: rtl/pp_sync_bus.sv
// Module: multi-stage synchroniser for a bus of independent asynchronous lines.
// Assumes: each bit is used as an independent level; no bus coherence is
// implied. STAGES must be at least 2. Reset loads RST_VAL into every stage.
module pp_sync_bus #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] chain [STAGES];

    // Shift the asynchronous inputs through the synchroniser stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pp_edge_det.sv
// Module: per-bit change detector on already synchronised levels.
// Assumes: inputs are synchronous to clk. A change pulse is one cycle wide
// and lasts for the cycle in which the new level is first visible.
module pp_edge_det #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] chg
);

    logic [W-1:0] prev_q;

    // Remember the previous level of every watched line
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        // Flag any difference between the current and previous level
        always_comb chg[g] = lvl[g] ^ prev_q[g];
    end

endmodule

// File: rtl/pp_mode_fsm.sv
// Module: mode state machine. Enters negotiation from compatibility only,
// captures the extensibility byte on the strobe fall, decodes it and tracks
// the ECP direction.
// Assumes: all inputs synchronised; edge inputs are single-cycle pulses.
module pp_mode_fsm
    import pp_neg_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] NIBBLE_CODE = 8'h00,
    parameter logic [DATA_W-1:0] BYTE_CODE   = 8'h01,
    parameter logic [DATA_W-1:0] ECP_CODE    = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lvl,
    input  logic              sel_chg,
    input  logic              feed_lvl,
    input  logic              stb_lvl,
    input  logic              stb_chg,
    input  logic              init_chg,
    input  logic [DATA_W-1:0] data_s,
    output pp_mode_e          mode,
    output logic              negotiating,
    output logic [DATA_W-1:0] ext_byte,
    output logic              rev_dir,
    output logic              neg_start,
    output logic              dir_flip
);

    pp_state_e         state_q, state_d;
    logic [DATA_W-1:0] ext_q, ext_d;
    logic              dir_q, dir_d;
    logic              sel_rise;
    logic              stb_fall;
    pp_state_e         decoded;

    // Qualify the raw change pulses with the new line level
    always_comb begin
        sel_rise = sel_chg & sel_lvl;
        stb_fall = stb_chg & ~stb_lvl;
    end

    // Map the presented extensibility byte to its target state
    always_comb begin
        if (data_s == ECP_CODE)         decoded = ST_ECP;
        else if (data_s == BYTE_CODE)   decoded = ST_BYTE;
        else if (data_s == NIBBLE_CODE) decoded = ST_NIBBLE;
        else                            decoded = ST_COMPAT;
    end

    // Next-state, capture and direction logic
    always_comb begin
        state_d   = state_q;
        ext_d     = ext_q;
        dir_d     = dir_q;
        neg_start = 1'b0;
        dir_flip  = 1'b0;
        case (state_q)
            ST_COMPAT: begin
                if (sel_rise && !feed_lvl) begin
                    state_d   = ST_NEGO;
                    neg_start = 1'b1;
                end
            end
            ST_NEGO: begin
                if (!sel_lvl) begin
                    state_d = ST_COMPAT;
                end else if (stb_fall) begin
                    ext_d   = data_s;
                    state_d = decoded;
                    dir_d   = 1'b0;
                end
            end
            ST_NIBBLE, ST_BYTE: begin
                if (!sel_lvl) state_d = ST_COMPAT;
            end
            ST_ECP: begin
                if (!sel_lvl) begin
                    state_d = ST_COMPAT;
                    dir_d   = 1'b0;
                end else if (init_chg) begin
                    dir_d    = ~dir_q;
                    dir_flip = 1'b1;
                end
            end
            default: begin
                state_d = ST_COMPAT;
                dir_d   = 1'b0;
            end
        endcase
    end

    // State, captured byte and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COMPAT;
            ext_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ext_q   <= ext_d;
            dir_q   <= dir_d;
        end
    end

    // Present the software-visible mode; negotiation reports compatibility
    always_comb begin
        case (state_q)
            ST_NIBBLE: mode = MODE_NIBBLE;
            ST_BYTE:   mode = MODE_BYTE;
            ST_ECP:    mode = MODE_ECP;
            default:   mode = MODE_COMPAT;
        endcase
        negotiating = (state_q == ST_NEGO);
        ext_byte    = ext_q;
        rev_dir     = dir_q;
    end

endmodule

// File: rtl/pp_event_flags.sv
// Module: sticky event flags with write-one-to-clear.
// Assumes: set pulses are single cycle; a set in the same cycle as a clear
// of that flag leaves the flag set.
module pp_event_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pulse,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;

        // Hold the flag until cleared, letting a new event override the clear
        always_ff @(posedge clk) begin
            if (!rst_n)            flag_q <= 1'b0;
            else if (set_pulse[g]) flag_q <= 1'b1;
            else if (clr_we && clr_mask[g]) flag_q <= 1'b0;
        end

        assign flags[g] = flag_q;
    end

endmodule

// File: rtl/pp_mode_tracker.sv
// Module: top of the parallel port mode negotiation tracker (peripheral side).
// Synchronises host lines, detects edges, runs the mode machine and keeps
// the sticky event flags for software.
// Assumes: host lines are asynchronous to clk; host holds data stable across
// the strobe fall for at least the synchroniser depth.
module pp_mode_tracker
    import pp_neg_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] NIBBLE_CODE = 8'h00,
    parameter logic [DATA_W-1:0] BYTE_CODE   = 8'h01,
    parameter logic [DATA_W-1:0] ECP_CODE    = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_n,
    input  logic              host_feed_n,
    input  logic              host_stb_n,
    input  logic              host_init_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic              clr_we,
    input  logic [1:0]        clr_mask,
    output logic [1:0]        mode_o,
    output logic [DATA_W-1:0] ext_byte_o,
    output logic              negotiating_o,
    output logic              rev_dir_o,
    output logic              neg_evt_flag_o,
    output logic              dir_evt_flag_o
);

    localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1110;
    localparam logic [EDG_W-1:0] EDG_IDLE = 3'b110;

    logic [CTL_W-1:0]  ctl_raw, ctl_s;
    logic [EDG_W-1:0]  edg_lvl, edg_chg;
    logic [DATA_W-1:0] data_s;
    logic [FLG_W-1:0]  flag_set, flag_q;
    pp_mode_e          mode;
    logic              neg_start, dir_flip;

    // Gather host control lines into one vector for synchronisation
    always_comb begin
        ctl_raw           = '0;
        ctl_raw[CTL_SEL]  = host_sel_n;
        ctl_raw[CTL_FEED] = host_feed_n;
        ctl_raw[CTL_STB]  = host_stb_n;
        ctl_raw[CTL_INIT] = host_init_n;
    end

    pp_sync_bus #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_ctl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ctl_raw),
        .q_sync  (ctl_s)
    );

    pp_sync_bus #(
        .W       (DATA_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_data_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (host_data),
        .q_sync  (data_s)
    );

    // Select the lines whose edges matter
    always_comb begin
        edg_lvl           = '0;
        edg_lvl[EDG_SEL]  = ctl_s[CTL_SEL];
        edg_lvl[EDG_STB]  = ctl_s[CTL_STB];
        edg_lvl[EDG_INIT] = ctl_s[CTL_INIT];
    end

    pp_edge_det #(
        .W       (EDG_W),
        .RST_VAL (EDG_IDLE)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (edg_lvl),
        .chg   (edg_chg)
    );

    pp_mode_fsm #(
        .DATA_W      (DATA_W),
        .NIBBLE_CODE (NIBBLE_CODE),
        .BYTE_CODE   (BYTE_CODE),
        .ECP_CODE    (ECP_CODE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_lvl     (ctl_s[CTL_SEL]),
        .sel_chg     (edg_chg[EDG_SEL]),
        .feed_lvl    (ctl_s[CTL_FEED]),
        .stb_lvl     (ctl_s[CTL_STB]),
        .stb_chg     (edg_chg[EDG_STB]),
        .init_chg    (edg_chg[EDG_INIT]),
        .data_s      (data_s),
        .mode        (mode),
        .negotiating (negotiating_o),
        .ext_byte    (ext_byte_o),
        .rev_dir     (rev_dir_o),
        .neg_start   (neg_start),
        .dir_flip    (dir_flip)
    );

    // Route the machine's event pulses to their flag slots
    always_comb begin
        flag_set          = '0;
        flag_set[FLG_NEG] = neg_start;
        flag_set[FLG_DIR] = dir_flip;
    end

    pp_event_flags #(
        .N (FLG_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (flag_set),
        .clr_we    (clr_we),
        .clr_mask  (clr_mask),
        .flags     (flag_q)
    );

    // Drive the software-facing outputs
    always_comb begin
        mode_o         = mode;
        neg_evt_flag_o = flag_q[FLG_NEG];
        dir_evt_flag_o = flag_q[FLG_DIR];
    end

endmodule

// File: rtl/pp_mode_tracker_chk.sv
// Module: property checker for pp_mode_tracker, bound to every instance.
// Assumes: observes the top-level ports only.
module pp_mode_tracker_chk
    import pp_neg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_we,
    input logic [1:0]        clr_mask,
    input logic [1:0]        mode_o,
    input logic [DATA_W-1:0] ext_byte_o,
    input logic              negotiating_o,
    input logic              rev_dir_o,
    input logic              neg_evt_flag_o,
    input logic              dir_evt_flag_o
);

    logic rst_seen_q;

    // Record the reset level seen at the previous edge
    always_ff @(posedge clk) rst_seen_q <= rst_n;

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen_q == 1'b0) begin
            reset_state_chk: assert (mode_o == MODE_COMPAT && !negotiating_o && ext_byte_o == '0
                                     && !rev_dir_o && !neg_evt_flag_o && !dir_evt_flag_o)
                else $error("reset state wrong");
        end
    end

    // R2
    neg_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(neg_evt_flag_o) |-> negotiating_o);

    // R4
    mode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_COMPAT && $past(mode_o) == MODE_COMPAT) |-> $past(negotiating_o));

    // R2
    nego_in_compat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        negotiating_o |-> mode_o == MODE_COMPAT);

    // R6
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_COMPAT && $past(mode_o) != MODE_COMPAT) |-> $stable(ext_byte_o));

    // R3
    ext_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_byte_o) |-> $past(negotiating_o));

    // R9
    dir_only_ecp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rev_dir_o) |-> $past(mode_o) == MODE_ECP);

    // R5
    dir_forward_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rev_dir_o |-> mode_o == MODE_ECP);

    // R7
    neg_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_evt_flag_o && !(clr_we && clr_mask[0])) |=> neg_evt_flag_o);

    // R7
    dir_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_evt_flag_o && !(clr_we && clr_mask[1])) |=> dir_evt_flag_o);

endmodule

bind pp_mode_tracker pp_mode_tracker_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr_we         (clr_we),
    .clr_mask       (clr_mask),
    .mode_o         (mode_o),
    .ext_byte_o     (ext_byte_o),
    .negotiating_o  (negotiating_o),
    .rev_dir_o      (rev_dir_o),
    .neg_evt_flag_o (neg_evt_flag_o),
    .dir_evt_flag_o (dir_evt_flag_o)
);

// File: tb/pp_mode_tracker_bench.sv
`timescale 1ns/1ps
module pp_mode_tracker_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_n, feed_n, stb_n, init_n;
    logic [7:0] data;
    logic       clr_we;
    logic [1:0] clr_mask;
    logic [1:0] mode;
    logic [7:0] ext;
    logic       nego, dir, nflag, dflag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pp_mode_tracker u_pp_mode_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_sel_n     (sel_n),
        .host_feed_n    (feed_n),
        .host_stb_n     (stb_n),
        .host_init_n    (init_n),
        .host_data      (data),
        .clr_we         (clr_we),
        .clr_mask       (clr_mask),
        .mode_o         (mode),
        .ext_byte_o     (ext),
        .negotiating_o  (nego),
        .rev_dir_o      (dir),
        .neg_evt_flag_o (nflag),
        .dir_evt_flag_o (dflag)
    );

    typedef struct packed {
        logic       sel;
        logic       feed;
        logic       stb;
        logic       init;
        logic [7:0] data;
        logic [1:0] clr;
        logic [1:0] e_mode;
        logic       e_nego;
        logic [7:0] e_ext;
        logic       e_dir;
        logic       e_nf;
        logic       e_df;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 31;
    // sel feed stb init data clr | mode nego ext dir nf df | requirement
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b1,1'b1,8'h00,2'd0, 2'd0,1'b0,8'h00,1'b0,1'b0,1'b0, 4'd2},  // R2 feed high
        '{1'b0,1'b1,1'b1,1'b1,8'h00,2'd0, 2'd0,1'b0,8'h00,1'b0,1'b0,1'b0, 4'd2},
        '{1'b0,1'b0,1'b1,1'b1,8'h10,2'd0, 2'd0,1'b0,8'h00,1'b0,1'b0,1'b0, 4'd3},  // R3 no strobe
        '{1'b1,1'b0,1'b1,1'b1,8'h10,2'd0, 2'd0,1'b1,8'h00,1'b0,1'b1,1'b0, 4'd2},  // R2 start
        '{1'b1,1'b0,1'b0,1'b1,8'h10,2'd0, 2'd3,1'b0,8'h10,1'b0,1'b1,1'b0, 4'd4},  // R4 ECP
        '{1'b1,1'b1,1'b1,1'b1,8'h10,2'd0, 2'd3,1'b0,8'h10,1'b0,1'b1,1'b0, 4'd4},
        '{1'b1,1'b1,1'b1,1'b0,8'h10,2'd0, 2'd3,1'b0,8'h10,1'b1,1'b1,1'b1, 4'd8},  // R8 fall
        '{1'b1,1'b1,1'b1,1'b1,8'h10,2'd0, 2'd3,1'b0,8'h10,1'b0,1'b1,1'b1, 4'd8},  // R8 rise
        '{1'b1,1'b1,1'b1,1'b1,8'h10,2'd2, 2'd3,1'b0,8'h10,1'b0,1'b1,1'b0, 4'd7},  // R7 dir clr
        '{1'b1,1'b1,1'b1,1'b0,8'h10,2'd0, 2'd3,1'b0,8'h10,1'b1,1'b1,1'b1, 4'd8},
        '{1'b1,1'b1,1'b0,1'b0,8'h01,2'd0, 2'd3,1'b0,8'h10,1'b1,1'b1,1'b1, 4'd6},  // R6 ignored
        '{1'b1,1'b1,1'b1,1'b0,8'h01,2'd3, 2'd3,1'b0,8'h10,1'b1,1'b0,1'b0, 4'd7},  // R7 both
        '{1'b0,1'b1,1'b1,1'b0,8'h01,2'd0, 2'd0,1'b0,8'h10,1'b0,1'b0,1'b0, 4'd5},  // R5 end ECP
        '{1'b0,1'b1,1'b1,1'b1,8'h01,2'd0, 2'd0,1'b0,8'h10,1'b0,1'b0,1'b0, 4'd9},  // R9 compat
        '{1'b0,1'b0,1'b1,1'b1,8'h00,2'd0, 2'd0,1'b0,8'h10,1'b0,1'b0,1'b0, 4'd3},
        '{1'b1,1'b0,1'b1,1'b1,8'h00,2'd0, 2'd0,1'b1,8'h10,1'b0,1'b1,1'b0, 4'd2},
        '{1'b1,1'b0,1'b0,1'b1,8'h00,2'd0, 2'd1,1'b0,8'h00,1'b0,1'b1,1'b0, 4'd4},  // R4 nibble
        '{1'b1,1'b0,1'b1,1'b1,8'h00,2'd0, 2'd1,1'b0,8'h00,1'b0,1'b1,1'b0, 4'd4},
        '{1'b1,1'b0,1'b1,1'b0,8'h00,2'd0, 2'd1,1'b0,8'h00,1'b0,1'b1,1'b0, 4'd9},  // R9 nibble
        '{1'b1,1'b0,1'b0,1'b0,8'h10,2'd0, 2'd1,1'b0,8'h00,1'b0,1'b1,1'b0, 4'd6},  // R6 nibble
        '{1'b0,1'b0,1'b1,1'b1,8'h10,2'd0, 2'd0,1'b0,8'h00,1'b0,1'b1,1'b0, 4'd5},
        '{1'b0,1'b0,1'b1,1'b1,8'h01,2'd0, 2'd0,1'b0,8'h00,1'b0,1'b1,1'b0, 4'd3},
        '{1'b1,1'b0,1'b1,1'b1,8'h01,2'd0, 2'd0,1'b1,8'h00,1'b0,1'b1,1'b0, 4'd2},
        '{1'b1,1'b0,1'b0,1'b1,8'h01,2'd0, 2'd2,1'b0,8'h01,1'b0,1'b1,1'b0, 4'd4},  // R4 byte
        '{1'b0,1'b0,1'b1,1'b1,8'h01,2'd0, 2'd0,1'b0,8'h01,1'b0,1'b1,1'b0, 4'd5},
        '{1'b1,1'b0,1'b1,1'b1,8'h55,2'd0, 2'd0,1'b1,8'h01,1'b0,1'b1,1'b0, 4'd2},
        '{1'b1,1'b0,1'b0,1'b1,8'h55,2'd0, 2'd0,1'b0,8'h55,1'b0,1'b1,1'b0, 4'd4},  // R4 unknown
        '{1'b0,1'b0,1'b1,1'b1,8'h55,2'd0, 2'd0,1'b0,8'h55,1'b0,1'b1,1'b0, 4'd5},
        '{1'b1,1'b0,1'b1,1'b1,8'h10,2'd0, 2'd0,1'b1,8'h55,1'b0,1'b1,1'b0, 4'd2},
        '{1'b0,1'b0,1'b1,1'b1,8'h10,2'd0, 2'd0,1'b0,8'h55,1'b0,1'b1,1'b0, 4'd5},  // R5 abort
        '{1'b0,1'b0,1'b1,1'b1,8'h10,2'd3, 2'd0,1'b0,8'h55,1'b0,1'b0,1'b0, 4'd7}   // R7 neg clr
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {19'd0, mode, nego, ext, dir, nflag, dflag};
    endfunction

    task automatic set_idle();
        sel_n = 1'b0; feed_n = 1'b1; stb_n = 1'b1; init_n = 1'b1; data = 8'h00;
        clr_we = 1'b0; clr_mask = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        set_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 state after reset
        check("R1 after reset", outs(), 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sel_n    = VECS[i].sel;
            feed_n   = VECS[i].feed;
            stb_n    = VECS[i].stb;
            init_n   = VECS[i].init;
            data     = VECS[i].data;
            clr_we   = (VECS[i].clr != 2'b00);
            clr_mask = VECS[i].clr;
            repeat (5) @(negedge clk);
            n_checks++;
            if (outs() !== {19'd0, VECS[i].e_mode, VECS[i].e_nego, VECS[i].e_ext,
                            VECS[i].e_dir, VECS[i].e_nf, VECS[i].e_df}) begin
                n_fails++;
                $display("FAIL vector %0d (R%0d): got %h expected %h", i, VECS[i].req, outs(),
                         {19'd0, VECS[i].e_mode, VECS[i].e_nego, VECS[i].e_ext,
                          VECS[i].e_dir, VECS[i].e_nf, VECS[i].e_df});
            end
        end

        // R10 latency and R7 set-over-clear, clear held throughout
        @(negedge clk);
        clr_we = 1'b1; clr_mask = 2'b01;
        sel_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R10 no response after two edges", {31'd0, nego}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check("R10 response on third edge", {31'd0, nego}, 32'd1);
        check("R7 set wins over clear", {31'd0, nflag}, 32'd1);
        @(negedge clk);
        check("R7 held clear acts next cycle", {31'd0, nflag}, 32'd0);
        clr_we = 1'b0; clr_mask = 2'b00;

        // Enter ECP, reverse direction, then reset mid-mode (R1)
        stb_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 ECP via directed", {30'd0, mode}, 32'd3);
        init_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 reversed before reset", {30'd0, dir, dflag}, 32'd3);
        set_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 during reset", outs(), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 after mid-mode reset", outs(), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule